// File: doc/BRIEF.md
# Transmit Descriptor-Ring DMA Engine

This block moves outgoing packets from system memory into a transmit FIFO. Software builds a linked ring of three-word descriptors in memory. Each descriptor holds a packet start address, a size word and a link to the next descriptor. Software then points the engine at the first descriptor and sets the run bit. The engine walks the ring, pushes each packet's words into the FIFO, and returns every finished descriptor to software by setting its empty flag.

The engine halts on its own in two cases: when it meets a descriptor that holds no data, and when any memory access returns a bus error. In both cases it clears its run bit. It keeps three sticky event flags and a wrapping count of sent packets. A masked OR of the flags drives a single interrupt line.

Top module: `txring_dma`

## Requirements
- R1: After reset all registers read zero, `irq` is low, and neither `mem_req` nor `fifo_wr` is asserted.
- R2: Register map (`reg_addr`):
  - 0 is the run-control register, bit 0 = run.
  - 1 is the first-descriptor pointer.
  - 2 is status.
  - 3 is the interrupt mask, bits 3:0.

  Writing 1 to run makes the engine fetch the descriptor at the pointer. The descriptor layout at address D is: D = packet start address, D+4 = size word, D+8 = next-descriptor address. A memory request holds its address until acknowledged.
- R3: A fetched size word with bit 31 set causes three things: the engine pushes no data, sets status bit 1 (underrun), and clears run.
- R4: No packet word is pushed unless `fifo_free` showed room for a maximum-size packet when the transfer began.
- R5: The size word's low `LEN_W` bits give a byte length. The engine pushes that many bytes rounded up to whole 32-bit words, read from ascending addresses in order. A length of zero pushes nothing.
- R6: After a packet's data, the engine writes the size word back to D+4 with bit 31 set and the other bits unchanged.
- R7: Each written-back packet sets status bit 0 (sent) and increments the count in status bits 23:16. The count wraps from 255 to 0.
- R8: After a packet, processing continues at the next-descriptor address read from that packet's descriptor, while run stays set.
- R9: A bus error on any access sets status bit 3 and clears run. No further access is made, and the current descriptor is not written back.
- R10: `irq` is high exactly when a status flag (bit 0, 1 or 3) and its mask bit are both set. A masked flag does not drive `irq`.
- R11: Writing 1 to a status flag bit clears it. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed with bus error |
| fifo_wr | output | 1 | Push one word into the FIFO |
| fifo_data | output | 32 | Word being pushed |
| fifo_free | input | FREE_W | Free FIFO space in words |
| irq | output | 1 | Interrupt request |

## Verification
A wrong internal state shows up at the ports in a few characteristic ways:
- A corrupted word counter or packet pointer shows as a wrong or missing FIFO word within two cycles of the faulty memory reply, and the scoreboard catches it at that push.
- A bad next-descriptor link or missing write-back appears later, as a wrong sent count or a size word left without its empty flag once run drops.
- A wrong stop or flag state is visible on the next register read or on `irq`.

The count wrap is driven through a long chain of zero-length packets.

// File: rtl/txring_pkg.sv
package txring_pkg;
   localparam int WORD_W = 32;

   localparam logic [1:0] RA_CTRL = 2'd0;
   localparam logic [1:0] RA_DPTR = 2'd1;
   localparam logic [1:0] RA_STAT = 2'd2;
   localparam logic [1:0] RA_MASK = 2'd3;

   localparam int ST_SENT = 0;
   localparam int ST_UNDR = 1;
   localparam int ST_RSVD = 2;
   localparam int ST_BERR = 3;
   localparam int NFLAG   = 4;
   localparam int CNT_LSB = 16;

   localparam int EMPTY_BIT = 31;

   typedef enum logic [2:0] {
      E_IDLE, E_SIZE, E_ADDR, E_NEXT, E_WAIT, E_DATA, E_WB
   } eng_state_t;
endpackage

// File: rtl/txring_regs.sv
module txring_regs
   import txring_pkg::*;
#(
   parameter int CNT_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              run_o,
   output logic [WORD_W-1:0] dptr_o,
   input  logic              ev_sent,
   input  logic              ev_underrun,
   input  logic              ev_buserr,
   output logic              irq
);
   logic             run_q;
   logic [WORD_W-1:0] dptr_q;
   logic [NFLAG-1:0] mask_q;
   logic [NFLAG-1:0] flag_w;
   logic [CNT_W-1:0] cnt_q;
   logic             stat_wr;

   assign stat_wr = reg_wr && (reg_addr == RA_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         dptr_q <= '0;
         mask_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (ev_underrun || ev_buserr)
            run_q <= 1'b0;
         else if (reg_wr && reg_addr == RA_CTRL)
            run_q <= reg_wdata[0];
         if (reg_wr && reg_addr == RA_DPTR)
            dptr_q <= reg_wdata;
         if (reg_wr && reg_addr == RA_MASK)
            mask_q <= reg_wdata[NFLAG-1:0];
         if (ev_sent)
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // sticky flags, one per event; an event beats a same-cycle clear
   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      if (i == ST_RSVD) begin : g_rsvd
         assign flag_w[i] = 1'b0;
      end else begin : g_live
         logic f_q;
         logic ev_i;
         assign ev_i = (i == ST_SENT) ? ev_sent :
                       (i == ST_UNDR) ? ev_underrun : ev_buserr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               f_q <= 1'b0;
            else if (ev_i)
               f_q <= 1'b1;
            else if (stat_wr && reg_wdata[i])
               f_q <= 1'b0;
         end
         assign flag_w[i] = f_q;
      end
   end

   assign irq    = |(flag_w & mask_q);
   assign run_o  = run_q;
   assign dptr_o = dptr_q;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: reg_rdata[0] = run_q;
         RA_DPTR: reg_rdata = dptr_q;
         RA_STAT: begin
            reg_rdata[NFLAG-1:0]       = flag_w;
            reg_rdata[CNT_LSB +: CNT_W] = cnt_q;
         end
         default: reg_rdata[NFLAG-1:0] = mask_q;
      endcase
   end

   p_underrun_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_underrun |=> (!run_q && flag_w[ST_UNDR]));

   p_buserr_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_buserr |=> (!run_q && flag_w[ST_BERR]));

   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_sent |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) && flag_w[ST_SENT]);

   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !reg_wr) |=> irq);
endmodule

// File: rtl/txring_engine.sv
module txring_engine
   import txring_pkg::*;
#(
   parameter int LEN_W         = 14,
   parameter int MAX_PKT_BYTES = 1536,
   parameter int FREE_W        = 10
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [WORD_W-1:0] dptr_i,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              fifo_wr,
   output logic [WORD_W-1:0] fifo_data,
   input  logic [FREE_W-1:0] fifo_free,
   output logic              ev_sent,
   output logic              ev_underrun,
   output logic              ev_buserr
);
   localparam int WC_W      = LEN_W - 1;
   localparam int MAX_WORDS = (MAX_PKT_BYTES + 3) / 4;
   localparam logic [FREE_W-1:0] ROOM = FREE_W'(MAX_WORDS);

   eng_state_t        state_q;
   logic [WORD_W-1:0] cur_q, pkt_q, size_q, next_q;
   logic [WC_W-1:0]   left_q;
   logic [LEN_W:0]    rnd_w;
   logic [WC_W-1:0]   words_w;

   assign rnd_w   = {1'b0, size_q[LEN_W-1:0]} + (LEN_W+1)'(3);
   assign words_w = rnd_w[LEN_W:2];

   always_comb begin
      mem_req  = (state_q != E_IDLE) && (state_q != E_WAIT);
      mem_we   = (state_q == E_WB);
      case (state_q)
         E_ADDR:  mem_addr = cur_q;
         E_NEXT:  mem_addr = cur_q + 32'd8;
         E_DATA:  mem_addr = pkt_q;
         default: mem_addr = cur_q + 32'd4;
      endcase
      mem_wdata = size_q;
      mem_wdata[EMPTY_BIT] = 1'b1;
   end

   assign fifo_wr     = (state_q == E_DATA) && mem_ack && !mem_err;
   assign fifo_data   = mem_rdata;
   assign ev_underrun = (state_q == E_SIZE) && mem_ack && !mem_err && mem_rdata[EMPTY_BIT];
   assign ev_buserr   = mem_req && mem_err;
   assign ev_sent     = (state_q == E_WB) && mem_ack && !mem_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= E_IDLE;
         cur_q   <= '0;
         pkt_q   <= '0;
         size_q  <= '0;
         next_q  <= '0;
         left_q  <= '0;
      end else if (mem_req && mem_err) begin
         state_q <= E_IDLE;
      end else begin
         case (state_q)
            E_IDLE: if (run_i) begin
               cur_q   <= dptr_i;
               state_q <= E_SIZE;
            end
            E_SIZE: if (mem_ack) begin
               size_q  <= mem_rdata;
               state_q <= mem_rdata[EMPTY_BIT] ? E_IDLE : E_ADDR;
            end
            E_ADDR: if (mem_ack) begin
               pkt_q   <= mem_rdata;
               state_q <= E_NEXT;
            end
            E_NEXT: if (mem_ack) begin
               next_q  <= mem_rdata;
               left_q  <= words_w;
               state_q <= E_WAIT;
            end
            E_WAIT: if (fifo_free >= ROOM)
               state_q <= (left_q == '0) ? E_WB : E_DATA;
            E_DATA: if (mem_ack) begin
               pkt_q  <= pkt_q + 32'd4;
               left_q <= left_q - WC_W'(1);
               if (left_q == WC_W'(1))
                  state_q <= E_WB;
            end
            E_WB: if (mem_ack) begin
               cur_q   <= next_q;
               state_q <= run_i ? E_SIZE : E_IDLE;
            end
            default: state_q <= E_IDLE;
         endcase
      end
   end

   p_fifo_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == E_DATA && $past(state_q) == E_WAIT) |-> ($past(fifo_free) >= ROOM));

   p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_wb_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[EMPTY_BIT]);
endmodule

// File: rtl/txring_dma.sv
module txring_dma
   import txring_pkg::*;
#(
   parameter int LEN_W         = 14,
   parameter int MAX_PKT_BYTES = 1536,
   parameter int FREE_W        = 10,
   parameter int CNT_W         = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_err,
   output logic              fifo_wr,
   output logic [31:0]       fifo_data,
   input  logic [FREE_W-1:0] fifo_free,
   output logic              irq
);
   localparam int MAX_WORDS = (MAX_PKT_BYTES + 3) / 4;

   if (LEN_W < 3 || LEN_W > 31) begin : g_bad_len
      $error("LEN_W must lie in 3..31");
   end
   if (MAX_PKT_BYTES < 1 || MAX_PKT_BYTES >= (1 << LEN_W)) begin : g_bad_max
      $error("MAX_PKT_BYTES must fit in LEN_W bits");
   end
   if (FREE_W < 1 || FREE_W > 24 || MAX_WORDS >= (1 << FREE_W)) begin : g_bad_free
      $error("FREE_W too narrow for a maximum-size packet");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 1..16");
   end

   logic              run_w;
   logic [WORD_W-1:0] dptr_w;
   logic              ev_sent_w, ev_undr_w, ev_berr_w;

   txring_regs #(.CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .run_o      (run_w),
      .dptr_o     (dptr_w),
      .ev_sent    (ev_sent_w),
      .ev_underrun(ev_undr_w),
      .ev_buserr  (ev_berr_w),
      .irq        (irq)
   );

   txring_engine #(
      .LEN_W        (LEN_W),
      .MAX_PKT_BYTES(MAX_PKT_BYTES),
      .FREE_W       (FREE_W)
   ) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_w),
      .dptr_i     (dptr_w),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_ack    (mem_ack),
      .mem_err    (mem_err),
      .fifo_wr    (fifo_wr),
      .fifo_data  (fifo_data),
      .fifo_free  (fifo_free),
      .ev_sent    (ev_sent_w),
      .ev_underrun(ev_undr_w),
      .ev_buserr  (ev_berr_w)
   );
endmodule

// File: tb/txring_dma_tb.sv
`timescale 1ns/1ps
module txring_dma_tb;
   localparam int FREE_W = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;
   logic        fifo_wr;
   logic [31:0] fifo_data;
   logic [FREE_W-1:0] fifo_free = 10'd512;
   logic        irq;

   logic        bw_en = 1'b0;
   logic [11:0] bw_a = '0;
   logic [31:0] bw_d = '0;
   logic        err_en = 1'b0;
   logic [31:0] err_addr = '0;
   logic [31:0] mem [0:4095];

   int checks = 0, fails = 0, mchecks = 0, mfails = 0, pushes = 0, cyc = 0;
   logic [31:0] expq [$];

   always #2.5 clk = ~clk;

   txring_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_free(fifo_free), .irq(irq)
   );

   // memory slave: one-cycle registered response
   always @(posedge clk) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      if (bw_en) mem[bw_a] <= bw_d;
      if (rst_n && mem_req && !mem_ack && !mem_err) begin
         if (err_en && mem_addr == err_addr) mem_err <= 1'b1;
         else begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
         end
      end
   end

   // scoreboard monitor and watchdog
   always @(negedge clk) begin
      cyc++;
      if (fifo_wr) begin
         logic [31:0] e;
         mchecks++;
         pushes++;
         if (expq.size() == 0) begin
            mfails++;
            $display("FAIL R5 unexpected push actual=%h expected=none", fifo_data);
         end else begin
            e = expq.pop_front();
            if (fifo_data !== e) begin
               mfails++;
               $display("FAIL R5 pushed word actual=%h expected=%h", fifo_data, e);
            end
         end
      end
      if (cyc == 150000) begin
         mfails++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, fails + mfails);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bw_en = 1'b1; bw_a = a[13:2]; bw_d = d;
      @(negedge clk);
      bw_en = 1'b0;
   endtask

   task automatic put_desc(input logic [31:0] d, input logic [31:0] pa,
                           input logic [31:0] sz, input logic [31:0] nx);
      put(d, pa); put(d + 4, sz); put(d + 8, nx);
   endtask

   task automatic expect_words(input logic [31:0] base, input int n);
      for (int i = 0; i < n; i++) expq.push_back(mem[base[13:2] + 12'(i)]);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_stop();
      logic [31:0] v;
      for (int i = 0; i < 20000; i++) begin
         rd(2'd0, v);
         if (v[0] == 1'b0) break;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      int p0;
      repeat (4) @(negedge clk);
      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd2, v); chk("R1 status", v, 0);
      rd(2'd3, v); chk("R1 mask", v, 0);
      chk("R1 irq/req/push", {29'd0, irq, mem_req, fifo_wr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", {30'd0, mem_req, fifo_wr}, 0);

      // packet of 10 bytes (3 words), then an empty descriptor: R2 R5 R6 R7 R3
      for (int i = 0; i < 3; i++) put(32'h400 + 4 * i, 32'hA000_0000 + i);
      put_desc(32'h100, 32'h400, 32'd10, 32'h110);
      put_desc(32'h110, 32'h480, 32'h8000_0004, 32'h100);
      wr(2'd3, 32'hF);
      wr(2'd1, 32'h100);
      expect_words(32'h400, 3);
      wr(2'd0, 32'h1);
      wait_stop();
      chk("R5 all words pushed", expq.size(), 0);
      rd(2'd2, v); chk("R7 R3 status sent+underrun count=1", v, 32'h0001_0003);
      chk("R6 write-back size word", mem[12'h104 >> 2], 32'h8000_000A);
      chk("R3 empty descriptor untouched", mem[12'h114 >> 2], 32'h8000_0004);
      chk("R10 irq raised", {31'd0, irq}, 1);

      // R11 write-one-to-clear
      wr(2'd2, 32'h0);
      rd(2'd2, v); chk("R11 write of 0 keeps flags", v, 32'h0001_0003);
      wr(2'd2, 32'h1);
      rd(2'd2, v); chk("R11 sent cleared only", v, 32'h0001_0002);
      chk("R10 irq still from underrun", {31'd0, irq}, 1);
      wr(2'd2, 32'h2);
      chk("R10 irq low with no flags", {31'd0, irq}, 0);

      // R4 FIFO room gating, R8 link following, R5 zero length
      put(32'h500, 32'hB000_0001); put(32'h504, 32'hB000_0002);
      put_desc(32'h140, 32'h500, 32'd8, 32'h1C0);
      put_desc(32'h1C0, 32'h700, 32'd0, 32'h110);
      fifo_free = 10'd383;
      p0 = pushes;
      wr(2'd1, 32'h140);
      wr(2'd0, 32'h1);
      repeat (60) @(negedge clk);
      chk("R4 no push without room", pushes - p0, 0);
      rd(2'd0, v); chk("R4 still running while waiting", v, 1);
      expect_words(32'h500, 2);
      fifo_free = 10'd384;
      wait_stop();
      chk("R5 R8 chain data pushed", expq.size(), 0);
      chk("R5 zero length pushes none", pushes - p0, 2);
      rd(2'd2, v); chk("R8 both packets counted", v, 32'h0003_0003);
      chk("R6 zero-length write-back", mem[12'h1C4 >> 2], 32'h8000_0000);

      // R9 bus error on second data word, interrupt only for bus error
      wr(2'd2, 32'hB);
      wr(2'd3, 32'h8);
      for (int i = 0; i < 4; i++) put(32'h600 + 4 * i, 32'hC000_0000 + i);
      put_desc(32'h200, 32'h600, 32'd16, 32'h100);
      err_addr = 32'h604; err_en = 1'b1;
      expect_words(32'h600, 1);
      wr(2'd1, 32'h200);
      wr(2'd0, 32'h1);
      wait_stop();
      err_en = 1'b0;
      chk("R9 only words before error", expq.size(), 0);
      rd(2'd2, v); chk("R9 bus-error flag, count kept", v, 32'h0003_0008);
      chk("R9 no write-back after error", mem[12'h204 >> 2], 32'd16);
      chk("R9 R10 irq on bus error", {31'd0, irq}, 1);

      // R10 masked underrun keeps irq low, unmasking raises it
      wr(2'd2, 32'hB);
      put_desc(32'h300, 32'h0, 32'h8000_0000, 32'h300);
      p0 = pushes;
      wr(2'd1, 32'h300);
      wr(2'd0, 32'h1);
      wait_stop();
      rd(2'd2, v); chk("R3 underrun flag", v, 32'h0003_0002);
      chk("R3 nothing pushed", pushes - p0, 0);
      chk("R10 masked flag keeps irq low", {31'd0, irq}, 0);
      wr(2'd3, 32'h2);
      chk("R10 unmask raises irq", {31'd0, irq}, 1);
      wr(2'd2, 32'h2);
      chk("R11 clear drops irq", {31'd0, irq}, 0);

      // R7 count wrap: 254 zero-length packets from count 3 -> 1
      for (int i = 0; i < 254; i++)
         put_desc(32'h1000 + 12 * i, 32'h0, 32'h0,
                  (i == 253) ? 32'h300 : 32'h1000 + 12 * (i + 1));
      wr(2'd1, 32'h1000);
      wr(2'd0, 32'h1);
      wait_stop();
      rd(2'd2, v); chk("R7 count wraps past 255", v, 32'h0001_0003);
      chk("R8 last link reached", mem[(32'h1000 + 12 * 253 + 4) >> 2], 32'h8000_0000);
      chk("R5 no stray words", expq.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks + mchecks, fails + mfails);
      $finish;
   end
endmodule